// File: doc/BRIEF.md
# Manchester Subcarrier Response Encoder

This block turns a tag's response into the on/off pattern that drives the load modulator of a passive HF transponder. After a one-cycle `start` pulse, which carries the request flags, it sends a start-of-frame pattern. It then takes response bytes one at a time through a ready/valid byte port and Manchester codes them, sending each byte's least significant bit first. The 16-bit CRC is simply the last two bytes on that port, and the source marks the final byte with `in_last`. The frame then closes with an end-of-frame pattern, and a one-cycle `done` pulse follows.

The clock is the carrier clock. Every bit is split into two half-bits. A half-bit is either "on", which is a square wave at one thirty-second of the clock, or "off". In single-subcarrier mode an off half-bit is quiet. In dual-subcarrier mode an off half-bit carries a second square wave at one twenty-eighth of the clock. Three lengths are available for the half-bit: low rate, high rate, and a doubled rate. Bytes pass through a one-byte staging register into the bit shifter as they are needed, so the block never holds the whole frame.

Top module: `rsp_manchester_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mod_out`, `in_ready` and `done` are 0.
- R2: A frame begins in the cycle after `start` is sampled high while idle. Its first eight half-bits are off, off, off, on, on, on, off, on.
- R3: Each data bit is sent least significant bit first. A 0 is an on half-bit followed by an off half-bit, and a 1 is an off half-bit followed by an on half-bit.
- R4: An on half-bit drives a square wave with a period of 32 clocks. The wave is high for the first 16 clocks, and its phase restarts at every half-bit boundary.
- R5: `req_flags[0]`=0 makes off half-bits quiet. `req_flags[0]`=1 makes them a square wave with a period of 28 clocks, high for the first 14 clocks, with its phase restarted at every half-bit boundary.
- R6: The half-bit length is set by the flags. With `req_flags[1]`=0 it is 4×HALF_HIGH clocks, and `req_flags[2]` is ignored. With `req_flags[1]`=1 and `req_flags[2]`=0 it is HALF_HIGH clocks. With both set it is HALF_HIGH/2 clocks.
- R7: After the byte marked by `in_last`, eight half-bits follow: on, off, on, on, on, off, off, off. The frame ends after them.
- R8: `done` is high for exactly one cycle, namely the first cycle after the last end-of-frame half-bit. In that cycle `mod_out` is 0.
- R9: `in_ready` is high only while a frame is active, the staging byte is empty, and the `in_last` byte has not yet been taken. The source must deliver each byte before the preceding pattern or byte finishes.
- R10: A `start` pulse that arrives during a frame is ignored. The flags and the output stream of that frame are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (sampled while idle) |
| req_flags | input | 3 | [0] dual subcarrier, [1] high rate, [2] doubled rate |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Response or CRC byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Encoder accepts a byte this cycle |
| mod_out | output | 1 | Load modulation drive |
| done | output | 1 | One-cycle pulse after end of frame |

## Verification
The assertions take two things for granted about the inputs. First, the byte source never leaves the staging register empty when the shifter needs its next byte. Second, once `in_valid` is raised it stays high until the byte is accepted. The bench keeps within both rules. It loads each frame's bytes into a feeder that raises `in_valid` before `start` and holds the byte until a handshake takes it. It then offers the next byte at once, so the staging register is refilled many half-bits before every byte boundary. The feeder also marks only the final queued byte with `in_last`.

// File: rtl/rsp_enc_pkg.sv
package rsp_enc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SOF  = 2'd1,
      ST_DATA = 2'd2,
      ST_EOF  = 2'd3
   } rsp_state_e;

   typedef enum logic [1:0] {
      RATE_LOW    = 2'd0,
      RATE_HIGH   = 2'd1,
      RATE_DOUBLE = 2'd2
   } rsp_rate_e;

   localparam int FLG_DUAL = 0;
   localparam int FLG_HIGH = 1;
   localparam int FLG_X2   = 2;
   localparam int FLG_W    = 3;

   // half-bit shapes, bit i = half-bit i, 1 = subcarrier on
   localparam logic [7:0] SOF_SHAPE = 8'b1011_1000;
   localparam logic [7:0] EOF_SHAPE = 8'b0001_1101;

   function automatic rsp_rate_e rate_of(input logic [FLG_W-1:0] f);
      if (!f[FLG_HIGH])   return RATE_LOW;
      else if (f[FLG_X2]) return RATE_DOUBLE;
      else                return RATE_HIGH;
   endfunction

endpackage

// File: rtl/rsp_halfbit_timer.sv
module rsp_halfbit_timer
   import rsp_enc_pkg::*;
#(
   parameter int HALF_HIGH = 256
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  rsp_rate_e rate,
   output logic      tick
);
   localparam int LEN_LOW  = 4 * HALF_HIGH;
   localparam int LEN_HIGH = HALF_HIGH;
   localparam int LEN_X2   = HALF_HIGH / 2;
   localparam int CW       = $clog2(LEN_LOW);

   initial begin
      assert (HALF_HIGH >= 4 && (HALF_HIGH % 2) == 0)
         else $error("HALF_HIGH must be even and at least 4");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   always_comb begin
      case (rate)
         RATE_LOW:    last = CW'(LEN_LOW - 1);
         RATE_DOUBLE: last = CW'(LEN_X2 - 1);
         default:     last = CW'(LEN_HIGH - 1);
      endcase
   end

   assign tick = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   // R6: the count never passes the selected half-bit length
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= last));
   // R6: every boundary restarts the count
   assert_tick_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));

endmodule

// File: rtl/rsp_subcarrier_gen.sv
module rsp_subcarrier_gen #(
   parameter int DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic wave
);
   localparam int CW   = $clog2(DIV);
   localparam int HALF = DIV / 2;

   initial begin
      assert (DIV >= 2 && (DIV % 2) == 0)
         else $error("DIV must be even and at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (restart)                cnt <= '0;
      else if (cnt == CW'(DIV - 1))    cnt <= '0;
      else                             cnt <= cnt + 1'b1;
   end

   assign wave = ({1'b0, cnt} < (CW+1)'(HALF));

   // R4: phase restarts high after each boundary
   assert_sc_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> wave);
   // R4: counter stays inside one period
   assert_sc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt} < (CW+1)'(DIV));

endmodule

// File: rtl/rsp_frame_seq.sv
module rsp_frame_seq
   import rsp_enc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [FLG_W-1:0] req_flags,
   input  logic             tick,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   output logic             in_ready,
   output logic             busy,
   output logic             sym_on,
   output logic             dual,
   output rsp_rate_e        rate,
   output logic             done
);
   rsp_state_e       state;
   logic [3:0]       pos;
   logic [7:0]       shreg;
   logic             cur_last;
   logic [7:0]       stg_data;
   logic             stg_full;
   logic             stg_last;
   logic             last_taken;
   logic [FLG_W-1:0] flags_q;
   logic             done_q;

   logic go, accept, end_sof, end_byte, end_eof, load;

   assign busy     = (state != ST_IDLE);
   assign go       = start && !busy;
   assign in_ready = busy && !stg_full && !last_taken;
   assign accept   = in_valid && in_ready;
   assign end_sof  = (state == ST_SOF)  && tick && (pos == 4'd7);
   assign end_byte = (state == ST_DATA) && tick && (pos == 4'd15);
   assign end_eof  = (state == ST_EOF)  && tick && (pos == 4'd7);
   assign load     = end_sof || (end_byte && !cur_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pos     <= '0;
         flags_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= end_eof;
         if (go) begin
            state   <= ST_SOF;
            pos     <= '0;
            flags_q <= req_flags;
         end else if (tick) begin
            if (end_sof || end_byte || end_eof) pos <= '0;
            else                                pos <= pos + 1'b1;
            if (end_sof)                     state <= ST_DATA;
            else if (end_byte && cur_last)   state <= ST_EOF;
            else if (end_eof)                state <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         cur_last <= 1'b0;
      end else if (load) begin
         shreg    <= stg_data;
         cur_last <= stg_last;
      end else if ((state == ST_DATA) && tick && pos[0]) begin
         shreg    <= {1'b0, shreg[7:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_data   <= '0;
         stg_full   <= 1'b0;
         stg_last   <= 1'b0;
         last_taken <= 1'b0;
      end else begin
         if (go) last_taken <= 1'b0;
         if (accept) begin
            stg_data <= in_data;
            stg_last <= in_last;
            stg_full <= 1'b1;
            if (in_last) last_taken <= 1'b1;
         end else if (load) begin
            stg_full <= 1'b0;
         end
      end
   end

   always_comb begin
      case (state)
         ST_SOF:  sym_on = SOF_SHAPE[pos[2:0]];
         ST_DATA: sym_on = pos[0] ? shreg[0] : ~shreg[0];
         ST_EOF:  sym_on = EOF_SHAPE[pos[2:0]];
         default: sym_on = 1'b0;
      endcase
   end

   assign dual = flags_q[FLG_DUAL];
   assign rate = rate_of(flags_q);
   assign done = done_q;

   // R9: source must refill staging before a byte boundary
   assert_no_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> stg_full);
   // R10: a start during a frame leaves the captured flags alone
   assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(flags_q));

endmodule

// File: rtl/rsp_manchester_encoder.sv
module rsp_manchester_encoder
   import rsp_enc_pkg::*;
#(
   parameter int HALF_HIGH  = 256,
   parameter int DIV_ON     = 32,
   parameter int DIV_ALT    = 28,
   parameter bit DUAL_SC_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] req_flags,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       in_ready,
   output logic       mod_out,
   output logic       done
);
   initial begin
      assert ((HALF_HIGH / 2) >= DIV_ON / 2)
         else $error("half-bit too short for subcarrier");
   end

   logic      tick, busy, sym_on, dual, restart;
   logic      on_wave, alt_wave;
   rsp_rate_e rate;

   rsp_frame_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .req_flags(req_flags),
      .tick     (tick),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .in_ready (in_ready),
      .busy     (busy),
      .sym_on   (sym_on),
      .dual     (dual),
      .rate     (rate),
      .done     (done)
   );

   rsp_halfbit_timer #(.HALF_HIGH(HALF_HIGH)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .rate (rate),
      .tick (tick)
   );

   assign restart = !busy || tick;

   rsp_subcarrier_gen #(.DIV(DIV_ON)) u_sc_on (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .wave   (on_wave)
   );

   generate
      if (DUAL_SC_EN) begin : g_alt
         rsp_subcarrier_gen #(.DIV(DIV_ALT)) u_sc_alt (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(restart),
            .wave   (alt_wave)
         );
      end else begin : g_no_alt
         assign alt_wave = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!busy)       mod_out = 1'b0;
      else if (sym_on) mod_out = on_wave;
      else if (dual)   mod_out = alt_wave;
      else             mod_out = 1'b0;
   end

   // R1: no modulation outside a frame
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mod_out);
   // R8: done is a single-cycle pulse, raised only once the frame has ended
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R9: source holds a byte until accepted
   assert_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> in_valid);

endmodule

// File: tb/rsp_manchester_encoder_tb_top.sv
module rsp_manchester_encoder_tb_top;
   localparam int H = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] req_flags = 3'b000;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       in_ready, mod_out, done;

   always #2 clk = ~clk;

   rsp_manchester_encoder #(.HALF_HIGH(H)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .req_flags(req_flags),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .in_ready(in_ready), .mod_out(mod_out), .done(done)
   );

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      bit    on;
      bit    dual;
      int    len;
      string tag;
   } hb_t;

   hb_t        sbq[$];
   logic [7:0] feed_q[$];
   logic [7:0] cur_bytes[$];
   event       frame_go;
   bit         mon_busy = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int half_len(input logic [2:0] f);
      if (!f[1]) return 4 * H;   // R6 low rate, doubled bit ignored
      if (f[2])  return H / 2;
      return H;
   endfunction

   task automatic push_hb(input bit on, input logic [2:0] f, input string tag);
      hb_t it;
      it.on = on; it.dual = f[0]; it.len = half_len(f); it.tag = tag;
      sbq.push_back(it);
   endtask

   // driver side of the scoreboard: expected half-bits from the requirements
   task automatic push_frame(input logic [2:0] f);
      logic [7:0] sof = 8'b1011_1000;   // R2 order off,off,off,on,on,on,off,on
      logic [7:0] eof = 8'b0001_1101;   // R7 order on,off,on,on,on,off,off,off
      for (int i = 0; i < 8; i++) push_hb(sof[i], f, "R2 SOF");
      foreach (cur_bytes[j]) begin
         for (int b = 0; b < 8; b++) begin   // R3 LSB first
            push_hb(!cur_bytes[j][b], f, "R3 data");
            push_hb(cur_bytes[j][b], f, "R3 data");
         end
      end
      for (int i = 0; i < 8; i++) push_hb(eof[i], f, "R7 EOF");
   endtask

   // byte source: holds each byte until taken, marks the final one
   initial begin
      forever begin
         wait (feed_q.size() > 0);
         @(negedge clk);
         in_data  = feed_q[0];
         in_last  = (feed_q.size() == 1);
         in_valid = 1'b1;
         while (in_ready !== 1'b1) @(negedge clk);
         @(negedge clk);
         void'(feed_q.pop_front());
         in_valid = 1'b0;
         in_last  = 1'b0;
      end
   end

   // monitor: pops expected half-bits and compares every clock of each
   initial begin
      forever begin
         @(frame_go);
         mon_busy = 1'b1;
         while (sbq.size() > 0) begin
            hb_t it;
            bit  bad;
            int  act_v, exp_v;
            it = sbq.pop_front();
            bad = 1'b0; act_v = 0; exp_v = 0;
            for (int k = 0; k < it.len; k++) begin
               int e;
               // R4 on wave, R5 off wave
               if (it.on)        e = ((k % 32) < 16) ? 1 : 0;
               else if (it.dual) e = ((k % 28) < 14) ? 1 : 0;
               else              e = 0;
               if (!bad && (mod_out !== 1'(e))) begin
                  bad = 1'b1; act_v = int'(mod_out); exp_v = e;
               end
               @(negedge clk);
            end
            chk(!bad, {it.tag, " half-bit waveform R4 R5 R6"}, act_v, exp_v);
         end
         chk(done === 1'b1, "R8 done after EOF", int'(done), 1);
         chk(mod_out === 1'b0, "R8 quiet with done", int'(mod_out), 0);
         @(negedge clk);
         chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
         mon_busy = 1'b0;
      end
   end

   task automatic run_frame(input logic [2:0] f, input bit poke);
      push_frame(f);
      foreach (cur_bytes[j]) feed_q.push_back(cur_bytes[j]);
      @(negedge clk);
      start = 1'b1; req_flags = f;
      @(negedge clk);
      start = 1'b0; req_flags = ~f;
      -> frame_go;
      #1;
      if (poke) begin
         // R10: a second start mid-frame with other flags
         repeat (3 * H) @(negedge clk);
         start = 1'b1; req_flags = f ^ 3'b011;
         @(negedge clk);
         start = 1'b0;
      end
      wait (mon_busy == 1'b0);
      chk(in_ready === 1'b0, "R9 ready low after frame", int'(in_ready), 0);
      chk(feed_q.size() == 0, "R9 all bytes taken", feed_q.size(), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(mod_out === 1'b0, "R1 reset mod_out", int'(mod_out), 0);
      chk(in_ready === 1'b0, "R1 reset in_ready", int'(in_ready), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(mod_out === 1'b0, "R1 idle mod_out", int'(mod_out), 0);
      chk(in_ready === 1'b0, "R1 idle in_ready", int'(in_ready), 0);
      chk(done === 1'b0, "R1 idle done", int'(done), 0);

      cur_bytes = '{8'hA5, 8'h3C, 8'h81};
      run_frame(3'b010, 1'b0);          // single, high rate
      cur_bytes = '{8'h00, 8'hFF, 8'h12};
      run_frame(3'b011, 1'b0);          // R5 dual, high rate
      cur_bytes = '{8'h5A, 8'h01};
      run_frame(3'b000, 1'b0);          // R6 single, low rate
      cur_bytes = '{8'hC3, 8'h7E, 8'h99, 8'h24};
      run_frame(3'b111, 1'b1);          // R10 dual, doubled rate
      cur_bytes = '{8'h6B, 8'hE2};
      run_frame(3'b100, 1'b0);          // R6 doubled bit ignored at low rate
      cur_bytes = '{8'hF0, 8'h0F};
      run_frame(3'b110, 1'b0);          // single, doubled rate

      repeat (4) @(negedge clk);
      chk(mod_out === 1'b0, "R1 idle after frames", int'(mod_out), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule